// File: doc/BRIEF.md
# MII Management Serial Master

This block runs one clause-22 management transaction at a time on the two-wire PHY management bus. Software first sets a control register that holds the clock divisor and a preamble-skip bit. For a write it then loads the 16-bit data register. Finally it writes a command word that names the PHY, the register and the direction. The block generates the management clock from the system clock and shifts the frame out. On a read it releases the data line and captures the PHY's reply. A busy flag covers the whole transaction.

Software polls `busy` and reads the data register once `busy` is low. While a transaction runs, the block ignores writes to the command, data and control registers. The line driver outside the block combines `mdio_o` and `mdio_oe` into the bidirectional pin and returns the pin level on `mdio_i`.

Top module: `mdio_master`

## Requirements
- R1: After reset `busy`, `mdc` and `mdio_oe` are low, the data register reads 0, the divisor is 32 and the preamble is enabled.
- R2: A command word has the register number in bits 4:0, the PHY address in bits 9:5, a read request in bit 10 and a write request in bit 11. It is accepted only while idle and only when exactly one of the two request bits is set. `busy` is high in the cycle after acceptance. A word with both request bits set, or with neither, starts nothing.
- R3: `busy` stays high for exactly 2·H·N cycles. N is 64 with the preamble and 32 without it. H is the divisor halved (rounded down), with a minimum of 1.
- R4: `mdc` is low while idle. While busy, `mdc` toggles every H cycles, starting low, so each bit has H high cycles.
- R5: Every frame is made of: 32 ones (unless the preamble is skipped), then start bits 01, then opcode 10 for a read or 01 for a write, then the PHY address MSB first, then the register number MSB first.
- R6: On a write, the master drives turnaround 10, then the 16 data-register bits MSB first. After the frame the data register still holds the written value.
- R7: On a read, `mdio_oe` is low for the 2 turnaround bits and the 16 data bits. The block samples `mdio_i` on each rising `mdc` edge, MSB first. The 16-bit result is in the data register when `busy` falls.
- R8: With the preamble-skip bit set, the frame has exactly 32 bit periods and no preamble.
- R9: While busy, writes to the command, data and control registers have no effect.
- R10: While busy, `mdio_o` changes only on a falling `mdc` edge.
- R11: The divisor field of the control register sets H. The reset value of the divisor is 32 (H = 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 12 | Command word (fields as in R2) |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Value to write to the data register |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_skip_pre | input | 1 | New preamble-skip bit |
| ctrl_div | input | 8 | New clock divisor |
| busy | output | 1 | Transaction in progress |
| data_q | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line level from the pad |
| mdio_o | output | 1 | Data line value to drive |
| mdio_oe | output | 1 | Data line drive enable |

## Verification
`busy` is due one cycle after the accepting edge. The bench samples it at the next falling clock edge and counts cycles until it drops, which gives the 2·H·N window exactly. The bench also acts as the PHY model. It detects rising and falling `mdc` edges on falling clock edges, so each frame bit is captured half a cycle after it settles, and read data is presented half a cycle after each falling `mdc`. The bench checks the data register and `busy` on the first falling clock edge after `busy` drops, and checks ignored commands four cycles later.

// File: rtl/mdio_pkg.sv
// Shared constants for the management master: frame sizes and
// command-word field positions. Assumes clause-22 framing only.
package mdio_pkg;
    localparam int PRE_LEN    = 32;
    localparam int FRM_LEN    = 32;
    localparam int SHIFT_W    = PRE_LEN + FRM_LEN;
    localparam int LEFT_W     = $clog2(SHIFT_W + 1);
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 5;
    localparam int RELEASE_N  = DATA_W + 2;
    localparam int CMD_W      = 12;
    localparam int CMD_REG_LSB = 0;
    localparam int CMD_PHY_LSB = 5;
    localparam int CMD_RD_BIT  = 10;
    localparam int CMD_WR_BIT  = 11;
    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] TA_WR    = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
// Management clock generator. While run is high it toggles mdc every
// half_cyc system cycles, starting low. rise and fall flag the cycle
// whose clock edge makes mdc go high or low. Assumes half_cyc >= 1.
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_cyc,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick = run && (cnt == half_cyc - 1'b1);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    // half-period counter and mdc toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame.sv
// Frame engine. When start arrives it loads the full frame into a shift
// register. The register advances on each fall flag. On a read, the
// engine captures mdio_i on each rise flag over the last 16 bits. done
// pulses with the final fall. Assumes start is given only while idle.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              skip_pre,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);
    logic [SHIFT_W-1:0] sh;
    logic [LEFT_W-1:0]  left;
    logic               rd;
    logic [FRM_LEN-1:0] body;

    assign body = {SOF_BITS, is_read ? OP_RD : OP_WR, phy, regad,
                   is_read ? 2'b00 : TA_WR,
                   is_read ? {DATA_W{1'b0}} : wdata};

    assign done    = active && fall && (left == LEFT_W'(1));
    assign mdio_o  = active && sh[SHIFT_W-1];
    assign mdio_oe = active && (!rd || (left > LEFT_W'(RELEASE_N)));

    // frame load, bit advance and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            left   <= '0;
            rd     <= 1'b0;
            active <= 1'b0;
        end else if (start && !active) begin
            sh     <= skip_pre ? {body, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, body};
            left   <= skip_pre ? LEFT_W'(FRM_LEN) : LEFT_W'(SHIFT_W);
            rd     <= is_read;
            active <= 1'b1;
        end else if (active && fall) begin
            if (left == LEFT_W'(1)) begin
                active <= 1'b0;
            end
            sh   <= sh << 1;
            left <= left - 1'b1;
        end
    end

    // read capture on rising mdc over the data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (active && rd && rise && (left <= LEFT_W'(DATA_W))) begin
            rdata <= {rdata[DATA_W-2:0], mdio_i};
        end
    end

    // R10
    mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active) && active && (mdio_o != $past(mdio_o)) |-> $past(fall));
endmodule

// File: rtl/mdio_master.sv
// Top of the management master. Holds the control and data registers,
// decodes and accepts command words, and joins the clock generator to
// the frame engine. Register writes are ignored while busy.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              ctrl_we,
    input  logic              ctrl_skip_pre,
    input  logic [DIV_W-1:0]  ctrl_div,
    output logic              busy,
    output logic [DATA_W-1:0] data_q,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic             skip_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] half_cyc;
    logic             accept;
    logic             want_rd;
    logic             want_wr;
    logic             rise;
    logic             fall;
    logic             done;
    logic             rd_q;
    logic [DATA_W-1:0] cap;

    assign want_rd  = cmd_wdata[CMD_RD_BIT];
    assign want_wr  = cmd_wdata[CMD_WR_BIT];
    assign accept   = cmd_we && !busy && (want_rd ^ want_wr);
    assign half_cyc = ((div_q >> 1) == '0) ? DIV_W'(1) : (div_q >> 1);

    // control register: divisor and preamble skip
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
            div_q  <= DIV_W'(DIV_RESET);
        end else if (ctrl_we && !busy) begin
            skip_q <= ctrl_skip_pre;
            div_q  <= ctrl_div;
        end
    end

    // direction of the running transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
        end else if (accept) begin
            rd_q <= want_rd;
        end
    end

    // data register: software write when idle, read result at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done && rd_q) begin
            data_q <= cap;
        end else if (data_we && !busy) begin
            data_q <= data_wdata;
        end
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half_cyc (half_cyc),
        .mdc      (mdc),
        .rise     (rise),
        .fall     (fall)
    );

    mdio_frame u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .is_read  (want_rd),
        .phy      (cmd_wdata[CMD_PHY_LSB +: ADDR_W]),
        .regad    (cmd_wdata[CMD_REG_LSB +: ADDR_W]),
        .wdata    (data_q),
        .skip_pre (skip_q),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .active   (busy),
        .done     (done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rdata    (cap)
    );

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && !busy && (want_rd ^ want_wr) |=> busy);
    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy |-> $stable(data_q));
    // R4
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe);
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [11:0] cmd_wdata = '0;
    logic        data_we = 1'b0;
    logic [15:0] data_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic        ctrl_skip_pre = 1'b0;
    logic [7:0]  ctrl_div = 8'd32;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic [15:0] data_q;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cur_div = 32;
    int nbits = 64;
    logic [15:0] pat = '0;
    int rcnt = 0;
    int hi_cnt = 0;
    int viol = 0;
    logic rec_bit [64];
    logic rec_oe  [64];
    logic mdc_q = 1'b0;
    logic busy_q = 1'b0;
    logic mo_q = 1'b0;

    always #4 clk = !clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .ctrl_we(ctrl_we),
        .ctrl_skip_pre(ctrl_skip_pre), .ctrl_div(ctrl_div), .busy(busy),
        .data_q(data_q), .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe)
    );

    // PHY model: records frame bits on rising mdc, drives reply after falling mdc
    always @(negedge clk) begin
        if (busy && !busy_q) begin
            rcnt = 0;
            hi_cnt = 0;
            viol = 0;
        end
        if (busy && busy_q && (mdio_o != mo_q) && !(mdc_q && !mdc)) viol++;
        if (mdc && !mdc_q) begin
            if (rcnt < 64) begin
                rec_bit[rcnt] = mdio_o;
                rec_oe[rcnt]  = mdio_oe;
            end
            rcnt++;
        end
        if (!mdc && mdc_q) begin
            if (rcnt >= nbits - 16 && rcnt < nbits) mdio_i = pat[nbits - 1 - rcnt];
            else mdio_i = 1'b1;
        end
        if (mdc) hi_cnt++;
        mdc_q  = mdc;
        busy_q = busy;
        mo_q   = mdio_o;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic txn(input bit rd, input logic [4:0] phy, input logic [4:0] regad,
                       input logic [15:0] val, input bit skip, input int div,
                       input bit set_ctrl, input bit inject);
        int h, cnt, bad_bit, bad_oe;
        logic [63:0] ev;
        if (set_ctrl) begin
            ctrl_we = 1'b1; ctrl_skip_pre = skip; ctrl_div = 8'(div);
            @(negedge clk);
            ctrl_we = 1'b0;
            cur_div = div;
        end
        if (!rd) begin
            data_we = 1'b1; data_wdata = val;
            @(negedge clk);
            data_we = 1'b0;
        end
        h = (cur_div / 2 == 0) ? 1 : cur_div / 2;
        nbits = skip ? 32 : 64;
        pat = val;
        cmd_we = 1'b1;
        cmd_wdata = {!rd, rd, phy, regad};
        @(negedge clk);
        cmd_we = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
        cnt = 0;
        while (busy) begin
            cnt++;
            if (inject && cnt == 3) begin
                cmd_we = 1'b1; cmd_wdata = {rd, !rd, ~phy, ~regad};
                data_we = 1'b1; data_wdata = ~val;
                ctrl_we = 1'b1; ctrl_skip_pre = !skip; ctrl_div = 8'd2;
            end else begin
                cmd_we = 1'b0; data_we = 1'b0; ctrl_we = 1'b0;
            end
            @(negedge clk);
        end
        cmd_we = 1'b0; data_we = 1'b0; ctrl_we = 1'b0;
        ev = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, regad,
              rd ? 2'b00 : 2'b10, rd ? 16'h0 : val};
        bad_bit = 0;
        bad_oe = 0;
        for (int i = 0; i < nbits; i++) begin
            bit exp_oe;
            exp_oe = !rd || (i < nbits - 18);
            if (rec_oe[i] != exp_oe) bad_oe++;
            if (exp_oe && rec_bit[i] != ev[nbits - 1 - i]) bad_bit++;
        end
        chk(cnt == 2 * h * nbits, "R3 busy length", 64'(cnt), 64'(2 * h * nbits));
        chk(rcnt == nbits, "R8 bit periods", 64'(rcnt), 64'(nbits));
        chk(hi_cnt == h * nbits, "R4/R11 mdc high cycles", 64'(hi_cnt), 64'(h * nbits));
        chk(bad_bit == 0, rd ? "R5 read header bits" : "R5/R6 write frame bits", 64'(bad_bit), 64'd0);
        chk(bad_oe == 0, "R7 drive enable pattern", 64'(bad_oe), 64'd0);
        chk(data_q == val, rd ? "R7 read data" : "R6 data kept", 64'(data_q), 64'(val));
        chk(viol == 0, "R10 mdio changes on falling mdc", 64'(viol), 64'd0);
        if (inject) begin
            repeat (4) @(negedge clk);
            chk(busy == 1'b0, "R9 command during busy ignored", 64'(busy), 64'd0);
            chk(data_q == val, "R9 data write during busy ignored", 64'(data_q), 64'(val));
        end
    endtask

    task automatic bad_cmd(input logic [1:0] flags);
        cmd_we = 1'b1;
        cmd_wdata = {flags, 5'h03, 5'h04};
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mdc == 1'b0, "R2 invalid request ignored", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy reset", 64'(busy), 64'd0);
        chk(mdc == 1'b0, "R1 mdc reset", 64'(mdc), 64'd0);
        chk(mdio_oe == 1'b0, "R1 oe reset", 64'(mdio_oe), 64'd0);
        chk(data_q == 16'h0, "R1 data reset", 64'(data_q), 64'd0);
        // R11 default divisor with preamble
        txn(1'b0, 5'h01, 5'h00, 16'hA5C3, 1'b0, 32, 1'b0, 1'b0);
        txn(1'b1, 5'h1F, 5'h1E, 16'h3C5A, 1'b0, 2, 1'b1, 1'b0);
        txn(1'b0, 5'h12, 5'h09, 16'h8001, 1'b1, 3, 1'b1, 1'b1);
        txn(1'b1, 5'h0A, 5'h15, 16'hFFFE, 1'b1, 32, 1'b1, 1'b1);
        txn(1'b1, 5'h00, 5'h1F, 16'h0001, 1'b0, 5, 1'b1, 1'b0);
        bad_cmd(2'b11);
        bad_cmd(2'b00);
        for (int p = 0; p < 32; p++) begin
            txn(p[0], 5'(p), 5'(31 - p), 16'(p * 16'h0811) ^ 16'h5A5A,
                p[1], 2 + (p % 3), 1'b1, (p % 8) == 7);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule